// File: doc/BRIEF.md
# I2C Controller Interrupt Status and FIFO Threshold Unit

This block collects the event flags of an I2C controller into a twelve-bit interrupt status word, gates that word with a per-source enable mask, and drives one registered interrupt line. Two of the twelve sources are not stored. TX-empty and RX-full are recomputed every cycle by comparing FIFO fill levels, which arrive as inputs, against two programmable thresholds. The other ten sources are sticky flags. Each is set by a one-cycle pulse on its event input and stays set until software reads an address that clears it.

Software reaches the unit through a simple register port with a separate write strobe and read strobe. Read data is registered and appears one cycle after the read strobe. A read of a clear address returns the flag value from before the clear and also performs the clear. There is one clear address per sticky source, plus one address that clears every sticky source at once. Clearing the TX-abort flag also clears a vector that records which abort causes have been reported.

Top module: `i2c_irq_unit`

Status bit positions (also used by the mask register): 0 RX underflow, 1 RX overflow, 2 RX full, 3 TX overflow, 4 TX empty, 5 read request, 6 TX abort, 7 RX done, 8 activity, 9 stop detected, 10 start detected, 11 general call.

Register addresses, as word indices on the 5-bit address:

| Address | Access | Content |
|---|---|---|
| 0x00 | read/write | mask, bits [11:0] |
| 0x01 | read | raw status |
| 0x02 | read | raw status AND mask |
| 0x03 | read/write | TX threshold, bits [3:0] |
| 0x04 | read/write | RX threshold, bits [3:0] |
| 0x05 | read | abort-source vector |
| 0x08 | read | clear all sticky sources; returns the sticky bits |
| 0x10 + k | read | clear source k; returns its old value in bit 0 |

## Requirements
- R1: After reset, the mask, both thresholds, every sticky flag, the abort-source vector, `irq_o` and `rd_data` are all zero.
- R2: A one-cycle pulse on `evt_i[k]`, for a sticky source k (any bit except 2 and 4), sets status bit k at the next clock edge. The bit then holds until a clear read.
- R3: A read of address 0x10+k clears only sticky bit k. Read data bit 0 carries the value bit k had before the clear. Every other status bit is left as it was.
- R4: A read of address 0x08 returns the sticky status bits and clears all of them and the abort-source vector. The level bits 2 and 4 are not affected.
- R5: A read of address 0x16, the clear for bit 6, clears the TX-abort flag and the abort-source vector together.
- R6: Status bit 4 (TX empty) is 1 exactly while `tx_lvl_i` is less than or equal to the TX threshold.
- R7: Status bit 2 (RX full) is 1 exactly while `rx_lvl_i` is greater than the RX threshold. A threshold of N therefore first fires at N+1 entries, and a threshold of 15 fires at 16 entries.
- R8: The level bits 2 and 4 ignore their event inputs and every clear read. They follow only their level condition.
- R9: If a source's event pulse falls in the same cycle as a read that clears that source, the flag stays set.
- R10: `irq_o` is registered. At every clock edge it takes the OR of (status AND mask) from the previous cycle. Address 0x02 reads back that masked status.
- R11: A write to the mask keeps bits [11:0]. A write to a threshold keeps bits [3:0]. A read of the same address returns the kept value, zero-extended.
- R12: While `evt_i[6]` pulses, `abrt_src_i` is ORed into the abort-source vector. The vector keeps accumulating across several aborts until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 5 | register write address |
| wr_data | input | 16 | register write data |
| rd_en | input | 1 | register read strobe; also triggers clears |
| rd_addr | input | 5 | register read address |
| rd_data | output | 16 | registered read data, valid the cycle after `rd_en` |
| evt_i | input | 12 | one-cycle event pulses, indexed by status bit |
| abrt_src_i | input | 16 | abort cause bits, sampled while `evt_i[6]` is high |
| tx_lvl_i | input | 5 | TX FIFO fill level, 0 to 16 |
| rx_lvl_i | input | 5 | RX FIFO fill level, 0 to 16 |
| irq_o | output | 1 | registered interrupt request |

## Verification
The assertions assume that the fill levels never exceed the FIFO depth of 16. They also assume that the register port is the only path by which a sticky flag can drop. This is why the hold and clear-all properties are conditioned on the absence of event pulses in the same cycle.

The stimulus changes levels and event pulses only on the falling edge, and keeps levels within 0 to 16. Same-cycle collisions between an event and a clear are staged on purpose, so that the event-wins rule is exercised and not avoided.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NSRC = 12;

  localparam int IDX_RXUF = 0;
  localparam int IDX_RXOF = 1;
  localparam int IDX_RXF  = 2;
  localparam int IDX_TXOF = 3;
  localparam int IDX_TXE  = 4;
  localparam int IDX_RDRQ = 5;
  localparam int IDX_ABRT = 6;
  localparam int IDX_RXDN = 7;
  localparam int IDX_ACT  = 8;
  localparam int IDX_STOP = 9;
  localparam int IDX_STRT = 10;
  localparam int IDX_GC   = 11;

  // sources that are stored; the two level sources are excluded
  localparam logic [NSRC-1:0] STICKY_MASK =
    ~((NSRC'(1) << IDX_RXF) | (NSRC'(1) << IDX_TXE));

  localparam int A_MASK    = 0;
  localparam int A_RAW     = 1;
  localparam int A_STAT    = 2;
  localparam int A_TXT     = 3;
  localparam int A_RXT     = 4;
  localparam int A_ABRT    = 5;
  localparam int A_CLRALL  = 8;
  localparam int A_CLRBASE = 16;
endpackage

// File: rtl/i2c_irq_level.sv
module i2c_irq_level #(
  parameter int LVL_W = 5,
  parameter int THR_W = 4
) (
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  output logic             tx_empty,
  output logic             rx_full
);
  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CMP_W-1:0] tx_l, rx_l, tx_t, rx_t;

  always_comb begin
    tx_l = CMP_W'(tx_lvl);
    rx_l = CMP_W'(rx_lvl);
    tx_t = CMP_W'(tx_thr);
    rx_t = CMP_W'(rx_thr);
    tx_empty = (tx_l <= tx_t);
    rx_full  = (rx_l >  rx_t);
  end
endmodule

// File: rtl/i2c_irq_sticky.sv
module i2c_irq_sticky
  import i2c_irq_pkg::*;
#(
  parameter int ABRT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   evt,
  input  logic [NSRC-1:0]   clr_vec,
  input  logic              abrt_clr,
  input  logic [ABRT_W-1:0] abrt_src_i,
  output logic [NSRC-1:0]   sticky_q,
  output logic [ABRT_W-1:0] abrt_q
);
  logic unused_evt;
  assign unused_evt = ^(evt & ~STICKY_MASK);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (STICKY_MASK[k]) begin : g_reg
      logic flag_q;
      always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= (flag_q & ~clr_vec[k]) | evt[k];
      end
      assign sticky_q[k] = flag_q;
    end else begin : g_none
      assign sticky_q[k] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) abrt_q <= '0;
    else     abrt_q <= (abrt_clr ? '0 : abrt_q) |
                       (evt[IDX_ABRT] ? abrt_src_i : '0);
  end
endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int THR_W  = 4,
  parameter int ABRT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NSRC-1:0]   status,
  input  logic [ABRT_W-1:0] abrt,
  output logic [NSRC-1:0]   mask_q,
  output logic [THR_W-1:0]  tx_thr_q,
  output logic [THR_W-1:0]  rx_thr_q,
  output logic [NSRC-1:0]   clr_vec,
  output logic              abrt_clr
);
  logic unused_wr;
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_MASK): mask_q   <= wr_data[NSRC-1:0];
        ADDR_W'(A_TXT):  tx_thr_q <= wr_data[THR_W-1:0];
        ADDR_W'(A_RXT):  rx_thr_q <= wr_data[THR_W-1:0];
        default: ;
      endcase
    end
  end

  // clear decode: per-source address or the combined one
  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      clr_vec[k] = rd_en && STICKY_MASK[k] &&
                   ((rd_addr == ADDR_W'(A_CLRALL)) ||
                    (rd_addr == ADDR_W'(A_CLRBASE + k)));
    end
    abrt_clr = clr_vec[IDX_ABRT];
  end

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADDR_W'(A_MASK):   rd_mux = DATA_W'(mask_q);
      ADDR_W'(A_RAW):    rd_mux = DATA_W'(status);
      ADDR_W'(A_STAT):   rd_mux = DATA_W'(status & mask_q);
      ADDR_W'(A_TXT):    rd_mux = DATA_W'(tx_thr_q);
      ADDR_W'(A_RXT):    rd_mux = DATA_W'(rx_thr_q);
      ADDR_W'(A_ABRT):   rd_mux = DATA_W'(abrt);
      ADDR_W'(A_CLRALL): rd_mux = DATA_W'(status & STICKY_MASK);
      default: begin
        for (int k = 0; k < NSRC; k++) begin
          if (rd_addr == ADDR_W'(A_CLRBASE + k))
            rd_mux = DATA_W'(status[k] & STICKY_MASK[k]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int ABRT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [ABRT_W-1:0] abrt_src_i,
  input  logic [LVL_W-1:0]  tx_lvl_i,
  input  logic [LVL_W-1:0]  rx_lvl_i,
  output logic              irq_o
);
  logic [NSRC-1:0]   mask_w, clr_w, sticky_w, stat_w;
  logic [THR_W-1:0]  tx_thr_w, rx_thr_w;
  logic [ABRT_W-1:0] abrt_w;
  logic              abrt_clr_w, txe_w, rxf_w;

  i2c_irq_level #(.LVL_W(LVL_W), .THR_W(THR_W)) u_level (
    .tx_lvl(tx_lvl_i), .rx_lvl(rx_lvl_i),
    .tx_thr(tx_thr_w), .rx_thr(rx_thr_w),
    .tx_empty(txe_w), .rx_full(rxf_w)
  );

  i2c_irq_sticky #(.ABRT_W(ABRT_W)) u_sticky (
    .clk(clk), .rst(rst), .evt(evt_i), .clr_vec(clr_w),
    .abrt_clr(abrt_clr_w), .abrt_src_i(abrt_src_i),
    .sticky_q(sticky_w), .abrt_q(abrt_w)
  );

  always_comb begin
    stat_w          = sticky_w;
    stat_w[IDX_TXE] = txe_w;
    stat_w[IDX_RXF] = rxf_w;
  end

  i2c_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W),
                 .ABRT_W(ABRT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .status(stat_w), .abrt(abrt_w),
    .mask_q(mask_w), .tx_thr_q(tx_thr_w), .rx_thr_q(rx_thr_w),
    .clr_vec(clr_w), .abrt_clr(abrt_clr_w)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(stat_w & mask_w);
  end
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int ABRT_W = 16,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [NSRC-1:0]   evt_i,
  input logic [LVL_W-1:0]  tx_lvl_i,
  input logic [LVL_W-1:0]  rx_lvl_i,
  input logic              irq_o,
  input logic [NSRC-1:0]   status,
  input logic [NSRC-1:0]   mask,
  input logic [ABRT_W-1:0] abrt
);
  assert_txe_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_lvl_i == '0) |-> status[IDX_TXE]);

  assert_rxf_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_lvl_i == '0) |-> !status[IDX_RXF]);

  assert_evt_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & STICKY_MASK)) |=>
      ((status & $past(evt_i & STICKY_MASK)) == $past(evt_i & STICKY_MASK)));

  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !(|evt_i)) |=>
      ((status & STICKY_MASK) == $past(status & STICKY_MASK)));

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(A_CLRALL) && !(|evt_i)) |=>
      (((status & STICKY_MASK) == '0) && (abrt == '0)));

  assert_irq_track_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(status & mask))));
endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(
  .ADDR_W(ADDR_W), .ABRT_W(ABRT_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
  .evt_i(evt_i), .tx_lvl_i(tx_lvl_i), .rx_lvl_i(rx_lvl_i),
  .irq_o(irq_o), .status(stat_w), .mask(mask_w), .abrt(abrt_w)
);

// File: tb/i2c_irq_unit_tb.sv
`timescale 1ns/1ps
module i2c_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [11:0] evt_i = '0;
  logic [15:0] abrt_src_i = '0;
  logic [4:0]  tx_lvl_i = 5'd8;
  logic [4:0]  rx_lvl_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_irq_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .evt_i(evt_i), .abrt_src_i(abrt_src_i),
    .tx_lvl_i(tx_lvl_i), .rx_lvl_i(rx_lvl_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 5'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rd_data);
  endtask

  task automatic pulse(input int bits, input int src);
    @(negedge clk);
    evt_i = 12'(bits); abrt_src_i = 16'(src);
    @(negedge clk);
    evt_i = '0; abrt_src_i = '0;
  endtask

  task automatic t_reset;
    int d;
    check("R1 irq", int'(irq_o), 0);
    check("R1 rd_data", int'(rd_data), 0);
    rd(0, d); check("R1 mask", d, 0);
    rd(1, d); check("R1 raw status", d, 0);
    rd(3, d); check("R1 tx thr", d, 0);
    rd(5, d); check("R1 abort src", d, 0);
  endtask

  task automatic t_regs;
    int d;
    wr(0, 16'hFFFF); rd(0, d); check("R11 mask width", d, 16'h0FFF);
    wr(3, 16'h01F5); rd(3, d); check("R11 tx thr width", d, 5);
    wr(4, 16'h0033); rd(4, d); check("R11 rx thr width", d, 3);
    wr(0, 0);
  endtask

  task automatic t_txe;
    int d;
    tx_lvl_i = 5'd5; rd(1, d); check("R6 at threshold", d & 16'h10, 16'h10);
    tx_lvl_i = 5'd6; rd(1, d); check("R6 above threshold", d & 16'h10, 0);
    tx_lvl_i = 5'd0; rd(1, d); check("R6 empty fifo", d & 16'h10, 16'h10);
    tx_lvl_i = 5'd8;
  endtask

  task automatic t_rxf;
    int d;
    rx_lvl_i = 5'd3; rd(1, d); check("R7 equal threshold", d & 4, 0);
    rx_lvl_i = 5'd4; rd(1, d); check("R7 threshold plus one", d & 4, 4);
    wr(4, 15);
    rx_lvl_i = 5'd15; rd(1, d); check("R7 thr15 at 15", d & 4, 0);
    rx_lvl_i = 5'd16; rd(1, d); check("R7 thr15 at 16", d & 4, 4);
    rx_lvl_i = 5'd0;
  endtask

  task automatic t_sticky;
    int d;
    pulse(1 << 9, 0);
    rd(1, d); check("R2 stop flag set", d, 16'h0200);
    repeat (4) @(negedge clk);
    rd(1, d); check("R2 stop flag held", d, 16'h0200);
    pulse(1 << 1, 0);
    rd(16 + 9, d); check("R3 clear returns old", d, 1);
    rd(1, d); check("R3 only stop cleared", d, 16'h0002);
    rd(16 + 9, d); check("R3 second clear returns 0", d, 0);
    rd(16 + 1, d);
  endtask

  task automatic t_level_immune;
    int d;
    pulse((1 << 2) | (1 << 4), 0);
    rd(1, d); check("R8 level event ignored", d, 0);
    tx_lvl_i = 5'd0;
    rd(16 + 4, d); check("R8 level clear returns 0", d, 0);
    rd(1, d); check("R8 level survives clear", d, 16'h0010);
    rd(8, d);
    rd(1, d); check("R8 level survives clear-all", d, 16'h0010);
    tx_lvl_i = 5'd8;
  endtask

  task automatic t_abort;
    int d;
    pulse(1 << 6, 16'h0081);
    pulse(1 << 6, 16'h0100);
    rd(5, d); check("R12 abort src accumulates", d, 16'h0181);
    rd(1, d); check("R12 abort flag", d, 16'h0040);
    rd(16 + 6, d); check("R5 abort clear returns old", d, 1);
    rd(1, d); check("R5 abort flag cleared", d, 0);
    rd(5, d); check("R5 abort src cleared", d, 0);
  endtask

  task automatic t_clear_all;
    int d;
    pulse(16'h008B, 0);
    pulse(1 << 6, 16'h0004);
    rd(8, d); check("R4 clear-all returns sticky", d, 16'h00CB);
    rd(1, d); check("R4 all sticky cleared", d, 0);
    rd(5, d); check("R4 abort src cleared", d, 0);
  endtask

  task automatic t_collide;
    int d;
    pulse(1 << 8, 0);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 5'(16 + 8); evt_i = 12'(1 << 8);
    @(negedge clk);
    rd_en = 1'b0; evt_i = '0;
    rd(1, d); check("R9 event beats clear", d, 16'h0100);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 5'd8; evt_i = 12'(1 << 10);
    @(negedge clk);
    rd_en = 1'b0; evt_i = '0;
    rd(1, d); check("R9 event beats clear-all", d, 16'h0400);
    rd(8, d);
  endtask

  task automatic t_irq;
    int d;
    wr(0, 1 << 9);
    pulse(1 << 3, 0);
    repeat (2) @(negedge clk);
    check("R10 unmasked source silent", int'(irq_o), 0);
    pulse(1 << 9, 0);
    @(negedge clk);
    check("R10 enabled source raises irq", int'(irq_o), 1);
    rd(2, d); check("R10 masked status", d, 16'h0200);
    wr(0, 0);
    @(negedge clk);
    check("R10 mask off drops irq", int'(irq_o), 0);
    rd(8, d);
    wr(0, 1 << 4);
    tx_lvl_i = 5'd2;
    repeat (2) @(negedge clk);
    check("R10 level source raises irq", int'(irq_o), 1);
    tx_lvl_i = 5'd9;
    repeat (2) @(negedge clk);
    check("R10 level gone drops irq", int'(irq_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_txe();
    t_rxf();
    t_sticky();
    t_level_immune();
    t_abort();
    t_clear_all();
    t_collide();
    t_irq();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule